// File: doc/BRIEF.md
# Frame Base Address Update Controller

This block sits on the register side of a display controller and decides when the pixel fetch engine starts to use a new frame buffer. Software writes a start address into a pending register at any time during a frame. The block holds that value and copies it into the active base address only when a frame-start strobe arrives. The copy happens only if software wrote the pending register since the last copy. The active address therefore never changes in the middle of a scanned frame.

Each copy raises a "next base updated" status bit. This bit is the block's only interrupt source, and software uses it as its vertical-blanking tick. The raw bit is gated by an enable register. The gated value is readable as masked status and drives a single interrupt line. A write-one-to-clear register removes the bit. The register bus is a plain single-cycle write strobe with an address, and a read data path that follows the address combinationally.

Top module: `fbu_base_update_ctrl`

## Requirements
- R1: After reset the active base, the pending base, the interrupt enable and the raw status all read zero, and `irq` is low.
- R2: A write to the pending register (word offset 0) stores the write data with its two low bits forced to zero. The active base does not change until a frame-start strobe.
- R3: If the pending register was written since the last transfer, a cycle with `frame_start` high copies the pending value into `active_base`, visible after that clock edge. A `frame_start` with no write since the last transfer leaves `active_base` and the status unchanged.
- R4: When the pending register is written several times before a frame start, only the last value written is transferred.
- R5: A pending write in the same cycle as `frame_start` does not take part in that transfer. The earlier pending value, if any, is transferred, and the new value is transferred at the next frame start.
- R6: Each transfer sets raw status bit 0. Raw status is at offset 3 and bit 0 is its only bit.
- R7: Masked status (offset 4) equals raw status AND the enable bit (offset 2, bit 0), and `irq` is high exactly when masked status is nonzero. With enable at 0, masked status reads zero and `irq` stays low while raw status stays set.
- R8: Writing the clear register (offset 5) with bit 0 set clears raw status bit 0. Writing it with bit 0 at zero has no effect. Writing back the value read from masked status clears every pending source.
- R9: When a transfer and a clear of raw status bit 0 fall in the same cycle, the bit ends up set.
- R10: Offset 1 reads the active base. Offset 5 and the unused offsets 6 and 7 read zero. Writes to offsets 1, 3, 4, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| frame_start | input | 1 | One-cycle strobe at the frame boundary |
| active_base | output | 32 | Base address used by the pixel fetch engine |
| irq | output | 1 | Next-base-updated interrupt |

## Verification
The bench drives a pending write in the same cycle as a frame strobe. A design that let the new write take part in the transfer would expose a half-committed base, or would lose the follow-up transfer. It raises a transfer and a clear together, where a design giving priority to the clear drops an update interrupt. It repeats frame strobes with no new write, which catches a design that raises spurious interrupts or recopies a stale value. It also writes unaligned addresses, clears with bit 0 at zero and writes to read-only offsets. These expose a design that keeps the low address bits, clears on any write, or lets read-only registers be overwritten. Long random runs mix all of these operations against a bench model.

// File: rtl/fbu_pkg.sv
// Package: shared constants and types for the frame base update controller.
// Assumes a word-addressed register bus with a three-bit offset.
package fbu_pkg;

    localparam int unsigned REG_AW  = 3;
    localparam int unsigned SRC_NXT = 0;

    typedef enum logic [REG_AW-1:0] {
        OFS_PEND    = 3'd0,
        OFS_ACTIVE  = 3'd1,
        OFS_IRQ_EN  = 3'd2,
        OFS_IRQ_RAW = 3'd3,
        OFS_IRQ_MSK = 3'd4,
        OFS_IRQ_CLR = 3'd5
    } fbu_reg_e;

    typedef struct packed {
        logic pend;
        logic en;
        logic clr;
    } fbu_wstb_t;

endpackage

// File: rtl/fbu_reg_decode.sv
// Module: register write decode and read multiplexer.
// Assumes single-cycle write strobes; read data is combinational from the
// offset, and unmapped or write-only offsets read as zero.
module fbu_reg_decode
    import fbu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SRC_W  = 1
) (
    input  logic                   reg_wr,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      pend_i,
    input  logic [DATA_W-1:0]      active_i,
    input  logic [SRC_W-1:0]       en_i,
    input  logic [SRC_W-1:0]       raw_i,
    input  logic [SRC_W-1:0]       masked_i,
    output fbu_wstb_t              wstb_o,
    output logic [DATA_W-1:0]      rdata_o
);

    localparam int unsigned PAD_W = DATA_W - SRC_W;

    // Write strobe per writable register.
    always_comb begin
        wstb_o      = '0;
        wstb_o.pend = reg_wr && (reg_addr == OFS_PEND);
        wstb_o.en   = reg_wr && (reg_addr == OFS_IRQ_EN);
        wstb_o.clr  = reg_wr && (reg_addr == OFS_IRQ_CLR);
    end

    // Read data selection by offset.
    always_comb begin
        case (reg_addr)
            OFS_PEND:    rdata_o = pend_i;
            OFS_ACTIVE:  rdata_o = active_i;
            OFS_IRQ_EN:  rdata_o = {{PAD_W{1'b0}}, en_i};
            OFS_IRQ_RAW: rdata_o = {{PAD_W{1'b0}}, raw_i};
            OFS_IRQ_MSK: rdata_o = {{PAD_W{1'b0}}, masked_i};
            default:     rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/fbu_base_buf.sv
// Module: double-buffered base address with a transfer-armed flag.
// Assumes frame_start is a one-cycle strobe. The low ALIGN_BITS of each
// stored address are forced to zero. A write in a frame-start cycle arms
// the next transfer but does not take part in the current one.
module fbu_base_buf #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pend_i,
    input  logic [ADDR_W-1:0] wdata_i,
    input  logic              frame_start_i,
    output logic [ADDR_W-1:0] pend_o,
    output logic [ADDR_W-1:0] active_o,
    output logic              swap_o
);

    logic [ADDR_W-1:0] wdata_al;
    logic [ADDR_W-1:0] pend_q;
    logic [ADDR_W-1:0] active_q;
    logic              armed_q;

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign wdata_al = {wdata_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end else begin : g_noalign
            assign wdata_al = wdata_i;
        end
    endgenerate

    assign swap_o = frame_start_i && armed_q;

    // Capture the aligned pending address on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= '0;
        else if (wr_pend_i) pend_q <= wdata_al;
    end

    // Arm on a write; disarm on a transfer unless re-armed the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (wr_pend_i) armed_q <= 1'b1;
        else if (swap_o)    armed_q <= 1'b0;
    end

    // Copy the pending address to the active address at an armed frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)      active_q <= '0;
        else if (swap_o) active_q <= pend_q;
    end

    assign pend_o   = pend_q;
    assign active_o = active_q;

    // R3: the active address holds outside frame-start cycles.
    p_hold_between_frames_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(active_q));

    // R4: a transfer moves the pending value present in that cycle.
    p_transfer_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && armed_q) |=> (active_q == $past(pend_q)));

    // R3: a transfer without a new write leaves nothing armed.
    p_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && armed_q && !wr_pend_i) |=> !armed_q);

    // R5: any pending write arms the next transfer.
    p_write_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend_i |=> armed_q);

endmodule

// File: rtl/fbu_irq_ctrl.sv
// Module: raw status, enable mask, masked status and write-one-to-clear.
// Assumes set_i pulses one cycle per event; a set beats a clear in the
// same cycle so no event is lost.
module fbu_irq_ctrl #(
    parameter int unsigned SRC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_i,
    input  logic             wr_en_i,
    input  logic             wr_clr_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] raw_o,
    output logic [SRC_W-1:0] en_o,
    output logic [SRC_W-1:0] masked_o,
    output logic             irq_o
);

    logic [SRC_W-1:0] raw_q;
    logic [SRC_W-1:0] en_q;

    // Load the enable mask from a register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (wr_en_i) en_q <= wdata_i;
    end

    generate
        for (genvar i = 0; i < SRC_W; i++) begin : g_src
            // Per-source sticky status: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                        raw_q[i] <= 1'b0;
                else if (set_i[i])                 raw_q[i] <= 1'b1;
                else if (wr_clr_i && wdata_i[i])   raw_q[i] <= 1'b0;
            end

            // R9: an event always leaves its status bit set.
            p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> raw_q[i]);

            // R8: a one written to the clear register removes the bit.
            p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_clr_i && wdata_i[i] && !set_i[i]) |=> !raw_q[i]);

            // R6: status never rises without an event.
            p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(raw_q[i]) |-> $past(set_i[i]));
        end
    endgenerate

    assign masked_o = raw_q & en_q;
    assign irq_o    = |masked_o;
    assign raw_o    = raw_q;
    assign en_o     = en_q;

    // R7: the line stays low while the mask is cleared.
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);

endmodule

// File: rtl/fbu_base_update_ctrl.sv
// Module: frame base address update controller (top).
// Software writes a pending base; it becomes active at the next frame
// start and the transfer raises the next-base-updated interrupt.
// Assumes a word-offset register bus and a one-cycle frame_start strobe.
module fbu_base_update_ctrl
    import fbu_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              frame_start,
    output logic [ADDR_W-1:0] active_base,
    output logic              irq
);

    localparam int unsigned SRC_W = SRC_NXT + 1;

    fbu_wstb_t         wstb;
    logic [ADDR_W-1:0] pend;
    logic              swap;
    logic [SRC_W-1:0]  raw;
    logic [SRC_W-1:0]  en;
    logic [SRC_W-1:0]  masked;

    fbu_reg_decode #(.DATA_W(ADDR_W), .SRC_W(SRC_W)) u_decode (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .pend_i   (pend),
        .active_i (active_base),
        .en_i     (en),
        .raw_i    (raw),
        .masked_i (masked),
        .wstb_o   (wstb),
        .rdata_o  (reg_rdata)
    );

    fbu_base_buf #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_pend_i     (wstb.pend),
        .wdata_i       (reg_wdata),
        .frame_start_i (frame_start),
        .pend_o        (pend),
        .active_o      (active_base),
        .swap_o        (swap)
    );

    fbu_irq_ctrl #(.SRC_W(SRC_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (SRC_W'(swap) << SRC_NXT),
        .wr_en_i  (wstb.en),
        .wr_clr_i (wstb.clr),
        .wdata_i  (reg_wdata[SRC_W-1:0]),
        .raw_o    (raw),
        .en_o     (en),
        .masked_o (masked),
        .irq_o    (irq)
    );

    // R1: outputs are at their reset values in the cycle after reset.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (active_base == '0 && !irq));

    // R6: each transfer is followed by raised raw status.
    p_swap_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> raw[SRC_NXT]);

endmodule

// File: tb/fbu_base_update_ctrl_test.sv
module fbu_base_update_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        frame_start = 1'b0;
    logic [31:0] reg_rdata;
    logic [31:0] active_base;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_pend = '0;
    logic [31:0] m_act  = '0;
    bit m_flag = 1'b0, m_raw = 1'b0, m_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbu_base_update_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
        .active_base(active_base), .irq(irq)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_pend;
            3'd1:    return m_act;
            3'd2:    return {31'b0, m_en};
            3'd3:    return {31'b0, m_raw};
            3'd4:    return {31'b0, m_raw & m_en};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input logic [2:0] a, input string tag);
        reg_wr   = 1'b0;
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp_read(a));
    endtask

    // One clock: drive, update the model from the requirements, check outputs.
    task automatic cycle(input bit wr, input logic [2:0] a, input logic [31:0] d, input bit fs);
        bit swap;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; frame_start = fs;
        @(posedge clk);
        swap = fs && m_flag;
        if (swap) begin m_act = m_pend; m_raw = 1'b1; m_flag = 1'b0; end
        if (wr) begin
            case (a)
                3'd0: begin m_pend = {d[31:2], 2'b00}; m_flag = 1'b1; end
                3'd2: m_en = d[0];
                3'd5: if (d[0] && !swap) m_raw = 1'b0;
                default: ;
            endcase
        end
        #1;
        reg_wr = 1'b0; frame_start = 1'b0;
        check("R3 active_base", active_base, m_act);
        check("R7 irq", {31'b0, irq}, {31'b0, m_raw & m_en});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int a = 0; a < 5; a++) chk_reg(3'(a), "R1 reset register");
        check("R1 reset irq", {31'b0, irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 alignment and no early transfer
        cycle(1, 3'd0, 32'h1000_0007, 0);
        chk_reg(3'd0, "R2 pending aligned");
        check("R2 active unchanged", active_base, 32'h0);
        // R3 / R6 transfer with interrupt masked
        cycle(0, 3'd0, 0, 1);
        check("R3 transferred", active_base, 32'h1000_0004);
        chk_reg(3'd3, "R6 raw set");
        chk_reg(3'd4, "R7 masked zero when disabled");
        check("R7 irq low when disabled", {31'b0, irq}, 32'h0);
        // R3 frame without new write: no change, no new status
        cycle(1, 3'd5, 32'h1, 0);
        cycle(0, 3'd0, 0, 1);
        chk_reg(3'd3, "R3 no status without write");
        check("R3 active held", active_base, 32'h1000_0004);
        // R4 last write wins
        cycle(1, 3'd2, 32'h1, 0);
        cycle(1, 3'd0, 32'hAAAA_0000, 0);
        cycle(1, 3'd0, 32'hBBBB_0010, 0);
        cycle(0, 3'd0, 0, 1);
        check("R4 last value", active_base, 32'hBBBB_0010);
        check("R7 irq high", {31'b0, irq}, 32'h1);
        // R8 clear with bit0 zero has no effect, masked write-back clears
        cycle(1, 3'd5, 32'hFFFF_FFFE, 0);
        chk_reg(3'd3, "R8 zero-bit clear ignored");
        chk_reg(3'd4, "R8 masked readback");
        cycle(1, 3'd5, reg_rdata, 0);
        chk_reg(3'd3, "R8 write-back cleared");
        // R9 set wins over same-cycle clear
        cycle(1, 3'd0, 32'h2000_0000, 0);
        cycle(1, 3'd5, 32'h1, 1);
        chk_reg(3'd3, "R9 set wins");
        check("R9 irq stays", {31'b0, irq}, 32'h1);
        // R5 write coincident with frame start
        cycle(1, 3'd0, 32'h3000_0000, 0);
        cycle(1, 3'd0, 32'h4000_0000, 1);
        check("R5 earlier value moved", active_base, 32'h3000_0000);
        chk_reg(3'd0, "R5 new value pending");
        cycle(0, 3'd0, 0, 1);
        check("R5 new value next frame", active_base, 32'h4000_0000);
        // R10 read-only and unused offsets
        cycle(1, 3'd1, 32'hDEAD_BEEC, 0);
        cycle(1, 3'd3, 32'h0, 0);
        cycle(1, 3'd4, 32'h0, 0);
        cycle(1, 3'd6, 32'hFFFF_FFFF, 0);
        cycle(1, 3'd7, 32'hFFFF_FFFF, 0);
        for (int a = 0; a < 8; a++) chk_reg(3'(a), "R10 register map");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned op;
            bit fs;
            op = $urandom % 10;
            fs = ($urandom % 4) == 0;
            case (op)
                0, 1, 2: cycle(1, 3'd0, $urandom, fs);
                3:       cycle(1, 3'd2, $urandom, fs);
                4, 5:    cycle(1, 3'd5, $urandom, fs);
                6:       cycle(1, 3'($urandom % 8), $urandom, fs);
                default: cycle(0, 3'd0, 0, fs);
            endcase
            chk_reg(3'($urandom % 8), "R10 random readback");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule